// File: doc/BRIEF.md
# Dual-Read Register File

This block is the architectural register store of a simple in-order processor datapath. It holds thirty-two 32-bit entries and serves two operand reads and one result write in every cycle. Each read port takes a 5-bit index and returns that entry's contents through pure combinational selection, so the decode stage can present two source indices and have both operands settle within the same cycle.

The single write port is gated by an enable and commits on the falling clock edge. A result that is written in the first half of a cycle is therefore already visible to any reader sampled on the following rising edge. Entry zero is a constant: it reads as zero on both ports, and writes aimed at it are dropped. A synchronous, active-high reset is sampled on the falling edge and clears every entry.

Top module: `regfile_dual_read`

## Requirements
- R1: The block stores 31 writable 32-bit entries at indices 1 to 31. A 5-bit index selects the entry on each port.
- R2: Reading index 0 returns all zeros on port A and on port B at all times.
- R3: A write with `wr_en` high and `wr_sel` equal to 0 changes no entry. Index 0 still reads zero, and every other entry keeps its value.
- R4: While `wr_en` is low, a falling edge changes no entry, whatever values `wr_sel` and `wr_data` carry.
- R5: With `wr_en` high at a falling edge and `wr_sel` non-zero, `wr_data` is stored at that edge. Before the edge, a read of the same index returns the old value; after the edge, it returns the new value.
- R6: Read data follows the read index combinationally. It changes when the index changes, with no clock edge in between.
- R7: Ports A and B are independent. Each returns the entry named by its own index, in the same cycle, including when both name the same entry.
- R8: When `rst` is high at a falling edge, every entry reads zero after that edge. Writes presented on that edge are dropped.
- R9: A write changes only the entry named by `wr_sel`. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its falling edge |
| rst | input | 1 | Synchronous active-high reset, clears all entries |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Index of the entry to write |
| wr_data | input | 32 | Data to write |
| rd_sel_a | input | 5 | Read index for port A |
| rd_data_a | output | 32 | Contents of the entry chosen by `rd_sel_a` |
| rd_sel_b | input | 5 | Read index for port B |
| rd_data_b | output | 32 | Contents of the entry chosen by `rd_sel_b` |

## Verification
The bound checker verifies the following on every rising edge:
- Index 0 reads zero on both ports.
- A write committed at the previous falling edge is seen by any port that now names its target.
- After a reset edge, both ports read zero.

Other behaviours can only be shown by the bench's directed scenarios, which compare both ports against a shadow copy. These are:
- The old value being visible before the falling edge.
- A read following its index with no clock edge in between.
- Writes to index 0 or with the enable low leaving every entry untouched.
- A write leaving its neighbours alone.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int RF_ENTRIES = 32;
    localparam int RF_DATA_W  = 32;
    localparam int RF_SEL_W   = $clog2(RF_ENTRIES);
    localparam int RF_RD_PORTS = 2;

    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } rd_port_e;

    // Entry index 0 is the constant-zero entry.
    function automatic logic is_const_entry(input int idx);
        return idx == 0;
    endfunction

endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode
    import regfile_pkg::*;
#(
    parameter int ENTRIES = RF_ENTRIES,
    parameter int SEL_W   = $clog2(ENTRIES)
) (
    input  logic               wr_en,
    input  logic               rst,
    input  logic [SEL_W-1:0]   wr_sel,
    output logic [ENTRIES-1:0] row_we
);

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_row
            if (is_const_entry(i)) begin : g_const
                assign row_we[i] = 1'b0;
            end else begin : g_live
                assign row_we[i] = wr_en && !rst && (wr_sel == SEL_W'(i));
            end
        end
    endgenerate

endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import regfile_pkg::*;
#(
    parameter int ENTRIES = RF_ENTRIES,
    parameter int DATA_W  = RF_DATA_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ENTRIES-1:0]              row_we,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [ENTRIES-1:0][DATA_W-1:0]  rows
);

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
            if (is_const_entry(i)) begin : g_zero
                assign rows[i] = '0;
            end else begin : g_reg
                logic [DATA_W-1:0] q;
                // Falling-edge update: data lands half a cycle ahead of rising-edge readers.
                always_ff @(negedge clk) begin
                    if (rst) begin
                        q <= '0;
                    end else if (row_we[i]) begin
                        q <= wr_data;
                    end
                end
                assign rows[i] = q;
            end
        end
    endgenerate

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
#(
    parameter int ENTRIES = RF_ENTRIES,
    parameter int DATA_W  = RF_DATA_W,
    parameter int SEL_W   = $clog2(ENTRIES)
) (
    input  logic [SEL_W-1:0]                rd_sel,
    input  logic [ENTRIES-1:0][DATA_W-1:0]  rows,
    output logic [DATA_W-1:0]               rd_data
);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_data = rows[i];
            end
        end
    end

endmodule

// File: rtl/regfile_dual_read.sv
module regfile_dual_read
    import regfile_pkg::*;
#(
    parameter int ENTRIES = RF_ENTRIES,
    parameter int DATA_W  = RF_DATA_W,
    localparam int SEL_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [SEL_W-1:0]  rd_sel_b,
    output logic [DATA_W-1:0] rd_data_b
);

    logic [ENTRIES-1:0]             row_we;
    logic [ENTRIES-1:0][DATA_W-1:0] rows;
    logic [RF_RD_PORTS-1:0][SEL_W-1:0]  port_sel;
    logic [RF_RD_PORTS-1:0][DATA_W-1:0] port_data;

    rf_write_decode #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_decode (
        .wr_en  (wr_en),
        .rst    (rst),
        .wr_sel (wr_sel),
        .row_we (row_we)
    );

    rf_storage #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .row_we  (row_we),
        .wr_data (wr_data),
        .rows    (rows)
    );

    assign port_sel[PORT_A] = rd_sel_a;
    assign port_sel[PORT_B] = rd_sel_b;

    generate
        for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_port
            rf_read_port #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_rd (
                .rd_sel  (port_sel[p]),
                .rows    (rows),
                .rd_data (port_data[p])
            );
        end
    endgenerate

    assign rd_data_a = port_data[PORT_A];
    assign rd_data_b = port_data[PORT_B];

endmodule

// File: rtl/regfile_dual_read_checker.sv
module regfile_dual_read_checker #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [SEL_W-1:0]  rd_sel_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [SEL_W-1:0]  rd_sel_b,
    input logic [DATA_W-1:0] rd_data_b
);

    logic              seen_wen  = 1'b0;
    logic [SEL_W-1:0]  seen_sel  = '0;
    logic [DATA_W-1:0] seen_data = '0;
    logic              seen_rst  = 1'b0;

    // Record what the port presented at the last falling edge.
    always_ff @(negedge clk) begin
        seen_wen  <= wr_en && !rst;
        seen_sel  <= wr_sel;
        seen_data <= wr_data;
        seen_rst  <= rst;
    end

    assert_zero_port_a_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_sel_a == '0) |-> (rd_data_a == '0));

    assert_zero_port_b_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_sel_b == '0) |-> (rd_data_b == '0));

    assert_write_lands_a_R5: assert property (@(posedge clk) disable iff (rst)
        (seen_wen && seen_sel != '0 && rd_sel_a == seen_sel) |-> (rd_data_a == seen_data));

    assert_write_lands_b_R5: assert property (@(posedge clk) disable iff (rst)
        (seen_wen && seen_sel != '0 && rd_sel_b == seen_sel) |-> (rd_data_b == seen_data));

    assert_reset_clears_R8: assert property (@(posedge clk)
        seen_rst |-> (rd_data_a == '0 && rd_data_b == '0));

endmodule

bind regfile_dual_read regfile_dual_read_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel_a  (rd_sel_a),
    .rd_data_a (rd_data_a),
    .rd_sel_b  (rd_sel_b),
    .rd_data_b (rd_data_b)
);

// File: tb/regfile_dual_read_tb.sv
`timescale 1ns/1ps
module regfile_dual_read_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_sel_a = '0;
    logic [31:0] rd_data_a;
    logic [4:0]  rd_sel_b = '0;
    logic [31:0] rd_data_b;

    logic [31:0] shadow [32];
    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    regfile_dual_read u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
        .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Sweep every index on both ports (B in reverse) against the shadow copy.
    task automatic check_all(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_sel_a = 5'(i);
            rd_sel_b = 5'(31 - i);
            #0.05;
            check(req, rd_data_a, shadow[i]);
            check(req, rd_data_b, shadow[31 - i]);
        end
    endtask

    task automatic do_write(input logic [4:0] sel, input logic [31:0] data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk); #0.5;
        if (sel != 5'd0) shadow[sel] = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check_all("R8 reset state");
    endtask

    task automatic t_fill();
        for (int i = 1; i < 32; i++) do_write(5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101));
        check_all("R1 R9 fill pattern");
        do_write(5'd31, 32'hFFFFFFFF);
        do_write(5'd1, 32'h00000001);
        check_all("R9 neighbours untouched");
    endtask

    task automatic t_zero_write();
        do_write(5'd0, 32'hDEADBEEF);
        rd_sel_a = 5'd0; rd_sel_b = 5'd0; #0.1;
        check("R2 port A index 0", rd_data_a, 32'h0);
        check("R2 port B index 0", rd_data_b, 32'h0);
        check_all("R3 write to index 0 dropped");
    endtask

    task automatic t_disabled();
        @(posedge clk); #1;
        wr_en = 1'b0; wr_sel = 5'd5; wr_data = 32'h12345678;
        @(negedge clk); @(negedge clk); #0.5;
        rd_sel_a = 5'd5; #0.1;
        check("R4 disabled write ignored", rd_data_a, shadow[5]);
        check_all("R4 all entries unchanged");
    endtask

    task automatic t_same_addr();
        logic [31:0] old_v = shadow[7];
        @(posedge clk); #1;
        rd_sel_a = 5'd7; rd_sel_b = 5'd7;
        wr_en = 1'b1; wr_sel = 5'd7; wr_data = 32'h0BADF00D;
        #0.5;
        check("R5 old value before falling edge", rd_data_a, old_v);
        check("R7 port B same entry before edge", rd_data_b, old_v);
        @(negedge clk); #0.5;
        shadow[7] = 32'h0BADF00D;
        check("R5 new value after falling edge", rd_data_a, 32'h0BADF00D);
        check("R7 port B same entry after edge", rd_data_b, 32'h0BADF00D);
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic t_comb_read();
        @(posedge clk); #1;
        rd_sel_a = 5'd3; rd_sel_b = 5'd9; #0.2;
        check("R6 comb read A idx 3", rd_data_a, shadow[3]);
        check("R7 independent B idx 9", rd_data_b, shadow[9]);
        rd_sel_a = 5'd9; rd_sel_b = 5'd3; #0.2;
        check("R6 comb read A idx 9 same cycle", rd_data_a, shadow[9]);
        check("R6 comb read B idx 3 same cycle", rd_data_b, shadow[3]);
    endtask

    task automatic t_reset_mid();
        @(posedge clk); #1;
        rst = 1'b1; wr_en = 1'b1; wr_sel = 5'd12; wr_data = 32'hCAFECAFE;
        @(negedge clk); #0.5;
        for (int i = 0; i < 32; i++) shadow[i] = '0;
        check_all("R8 reset clears and drops write");
        @(posedge clk); #1;
        rst = 1'b0; wr_en = 1'b0;
        check_all("R8 cleared after release");
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_zero_write();
        t_disabled();
        t_same_addr();
        t_comb_read();
        t_reset_mid();
        do_write(5'd20, 32'h55AA55AA);
        check_all("R1 write after reset");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule